// File: doc/BRIEF.md
# Facility Data Link Byte Buffer

This block sits on the facility data link bit stream of a T1 framer and turns it into bytes in both directions. On the receive side each strobed serial bit is shifted into an 8-bit collector, least significant bit first. When a byte completes, the block presents it on a parallel output and raises a one-cycle "byte ready" pulse. In the same cycle it raises a match pulse if the byte equals either of two programmable compare values. Separately, a run detector watches the strobed receive bits and flags an abort once eight ones in a row have arrived.

On the transmit side software-facing logic writes a byte into a holding register. At every byte boundary the serializer takes the held byte, or a byte of all ones when nothing is held, and shifts it out least significant bit first, one bit per transmit strobe. The holding register is a two-state machine. HOLD_EMPTY moves to HOLD_LOADED on a write (transition WRITE). HOLD_LOADED moves back to HOLD_EMPTY when the serializer takes the byte at a boundary (transition TAKE). HOLD_LOADED stays in HOLD_LOADED when a write coincides with a take or arrives while a byte is held (transition REFILL). A one-cycle empty pulse marks each TAKE.

Top module: `fdl_byte_buf`

## Requirements
- R1: Receive bits are shifted in only on cycles with `rx_bit_en` high, first bit into bit 0. `rx_byte` changes only when the eighth strobed bit of a byte arrives, and then shows the completed byte in the cycle after that strobe.
- R2: `rx_full_pulse` is high for exactly one cycle, the cycle after the strobe carrying the eighth bit of a byte, and at no other time.
- R3: `rx_match_pulse` is high in the same cycle as `rx_full_pulse` when the completed byte equals `match_a` or `match_b`, and is low otherwise.
- R4: `rx_abort_pulse` is high for one cycle, the cycle after the strobe that delivers the eighth consecutive strobed 1 bit.
- R5: A run of ones fires the abort pulse once however long it lasts. A strobed 0 restarts the run. Unstrobed cycles neither extend nor restart the run.
- R6: `tx_bit` shows the current transmit bit and advances only on a `tx_bit_en` strobe. Each byte goes out least significant bit first. Every eighth strobe is a byte boundary where the next byte is loaded.
- R7: `tx_empty_pulse` is high for one cycle after a boundary strobe that takes a held byte, unless a write lands in that same cycle. No pulse appears when the holding register was already empty at the boundary.
- R8: When the holding register is empty at a byte boundary, the next eight transmitted bits are all ones.
- R9: A `tx_wr` stores `tx_wdata` and marks the holding register loaded. A write while loaded replaces the held byte, and only the last written byte is sent.
- R10: After reset all pulse outputs are low, `rx_byte` is zero, `tx_bit` is 1, the holding register is empty and both bit counters start a fresh byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_bit | input | 1 | Receive serial data bit |
| rx_bit_en | input | 1 | Receive bit strobe |
| match_a | input | DW | First compare value |
| match_b | input | DW | Second compare value |
| rx_byte | output | DW | Last completed receive byte |
| rx_full_pulse | output | 1 | Receive byte complete |
| rx_match_pulse | output | 1 | Completed byte equals a compare value |
| rx_abort_pulse | output | 1 | Eighth consecutive one received |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_wdata | input | DW | Byte to hold for transmission |
| tx_bit_en | input | 1 | Transmit bit strobe |
| tx_bit | output | 1 | Transmit serial data bit |
| tx_empty_pulse | output | 1 | Held byte taken, holding register now empty |

## Verification
The bench uses the default widths, a byte of 8 bits and an abort run of 8 ones. Because the run length equals the byte length, an abort can straddle a byte boundary. The bench exercises that straddling case together with byte alignment. Ones held on the input without a strobe are shown to leave the run count untouched. On the transmit side the bench reads whole bytes between boundaries and covers idle fill, a single load and an overwritten load.

// File: rtl/fdl_pkg.sv
`timescale 1ns/1ps
package fdl_pkg;
    typedef enum logic {
        HOLD_EMPTY  = 1'b0,
        HOLD_LOADED = 1'b1
    } hold_state_e;
endpackage

// File: rtl/fdl_rx_deser.sv
`timescale 1ns/1ps
module fdl_rx_deser #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_i,
    input  logic          bit_en,
    input  logic [DW-1:0] match_a,
    input  logic [DW-1:0] match_b,
    output logic [DW-1:0] byte_o,
    output logic          full_o,
    output logic          match_o
);
    localparam int CW = $clog2(DW);

    logic [DW-1:0] shreg;
    logic [DW-1:0] shreg_nxt;
    logic [CW-1:0] cnt;
    logic          last;

    assign shreg_nxt = {bit_i, shreg[DW-1:1]};
    assign last      = (cnt == CW'(DW-1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            cnt     <= '0;
            byte_o  <= '0;
            full_o  <= 1'b0;
            match_o <= 1'b0;
        end else begin
            full_o  <= 1'b0;
            match_o <= 1'b0;
            if (bit_en) begin
                shreg <= shreg_nxt;
                if (last) begin
                    cnt     <= '0;
                    byte_o  <= shreg_nxt;
                    full_o  <= 1'b1;
                    match_o <= (shreg_nxt == match_a) || (shreg_nxt == match_b);
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/fdl_abort_det.sv
`timescale 1ns/1ps
module fdl_abort_det #(
    parameter int RUN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic bit_en,
    output logic abort_o
);
    localparam int CW = $clog2(RUN + 1);

    logic [CW-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= '0;
            abort_o <= 1'b0;
        end else begin
            abort_o <= 1'b0;
            if (bit_en) begin
                if (!bit_i) begin
                    run <= '0;
                end else begin
                    if (run != CW'(RUN)) run <= run + CW'(1);
                    abort_o <= (run == CW'(RUN - 1));
                end
            end
        end
    end
endmodule

// File: rtl/fdl_tx_ser.sv
`timescale 1ns/1ps
module fdl_tx_ser
    import fdl_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          bit_en,
    output logic          bit_o,
    output logic          empty_pulse
);
    localparam int CW = $clog2(DW);

    hold_state_e   state, state_nxt;
    logic [DW-1:0] hold;
    logic [DW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          boundary;
    logic          take;

    assign boundary = bit_en && (cnt == CW'(DW-1));

    // next state of the holding register
    always_comb begin
        state_nxt = state;
        take      = 1'b0;
        unique case (state)
            HOLD_EMPTY: begin
                if (wr) state_nxt = HOLD_LOADED;                 // WRITE
            end
            HOLD_LOADED: begin
                if (boundary) begin
                    take      = 1'b1;
                    state_nxt = wr ? HOLD_LOADED : HOLD_EMPTY;   // REFILL / TAKE
                end
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= HOLD_EMPTY;
        else        state <= state_nxt;
    end

    // outputs: holding byte, serializer and empty event
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold        <= '0;
            sh          <= '1;
            cnt         <= '0;
            empty_pulse <= 1'b0;
        end else begin
            empty_pulse <= take && !wr;
            if (wr) hold <= wdata;
            if (bit_en) begin
                if (boundary) begin
                    sh  <= take ? hold : '1;
                    cnt <= '0;
                end else begin
                    sh  <= {1'b1, sh[DW-1:1]};
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    assign bit_o = sh[0];
endmodule

// File: rtl/fdl_byte_buf.sv
`timescale 1ns/1ps
module fdl_byte_buf #(
    parameter int DW        = 8,
    parameter int ABORT_RUN = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_bit,
    input  logic          rx_bit_en,
    input  logic [DW-1:0] match_a,
    input  logic [DW-1:0] match_b,
    output logic [DW-1:0] rx_byte,
    output logic          rx_full_pulse,
    output logic          rx_match_pulse,
    output logic          rx_abort_pulse,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_wdata,
    input  logic          tx_bit_en,
    output logic          tx_bit,
    output logic          tx_empty_pulse
);
    fdl_rx_deser #(.DW(DW)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (rx_bit),
        .bit_en  (rx_bit_en),
        .match_a (match_a),
        .match_b (match_b),
        .byte_o  (rx_byte),
        .full_o  (rx_full_pulse),
        .match_o (rx_match_pulse)
    );

    fdl_abort_det #(.RUN(ABORT_RUN)) u_abort (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_i   (rx_bit),
        .bit_en  (rx_bit_en),
        .abort_o (rx_abort_pulse)
    );

    fdl_tx_ser #(.DW(DW)) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (tx_wr),
        .wdata       (tx_wdata),
        .bit_en      (tx_bit_en),
        .bit_o       (tx_bit),
        .empty_pulse (tx_empty_pulse)
    );
endmodule

// File: rtl/fdl_byte_buf_chk.sv
`timescale 1ns/1ps
module fdl_byte_buf_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_bit,
    input logic          rx_bit_en,
    input logic [DW-1:0] rx_byte,
    input logic          rx_full_pulse,
    input logic          rx_match_pulse,
    input logic          rx_abort_pulse,
    input logic          tx_wr,
    input logic          tx_bit_en,
    input logic          tx_bit,
    input logic          tx_empty_pulse
);
    a_r1_byte_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_bit_en) |-> $stable(rx_byte));

    a_r2_full_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_pulse |-> $past(rx_bit_en));

    a_r2_full_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_pulse |=> !rx_full_pulse);

    a_r3_match_with_full: assert property (@(posedge clk) disable iff (!rst_n)
        rx_match_pulse |-> rx_full_pulse);

    a_r4_abort_on_one: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort_pulse |-> $past(rx_bit_en && rx_bit));

    a_r5_abort_once: assert property (@(posedge clk) disable iff (!rst_n)
        rx_abort_pulse |=> !rx_abort_pulse);

    a_r6_tx_bit_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tx_bit_en) |-> $stable(tx_bit));

    a_r7_empty_cause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_pulse |-> ($past(tx_bit_en) && !$past(tx_wr)));
endmodule

bind fdl_byte_buf fdl_byte_buf_chk #(.DW(DW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .rx_bit         (rx_bit),
    .rx_bit_en      (rx_bit_en),
    .rx_byte        (rx_byte),
    .rx_full_pulse  (rx_full_pulse),
    .rx_match_pulse (rx_match_pulse),
    .rx_abort_pulse (rx_abort_pulse),
    .tx_wr          (tx_wr),
    .tx_bit_en      (tx_bit_en),
    .tx_bit         (tx_bit),
    .tx_empty_pulse (tx_empty_pulse)
);

// File: tb/tb_fdl_byte_buf.sv
`timescale 1ns/1ps
module tb_fdl_byte_buf;
    localparam int DW = 8;
    localparam int NV = 5;
    // {expected match, byte}; compare values are A5 and 3C
    localparam logic [DW:0] VEC [NV] = '{
        {1'b1, 8'hA5}, {1'b1, 8'h3C}, {1'b0, 8'h00}, {1'b0, 8'h5A}, {1'b0, 8'hC3}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_bit = 1'b0, rx_bit_en = 1'b0;
    logic [DW-1:0] match_a = 8'hA5, match_b = 8'h3C;
    logic [DW-1:0] rx_byte;
    logic rx_full_pulse, rx_match_pulse, rx_abort_pulse;
    logic tx_wr = 1'b0;
    logic [DW-1:0] tx_wdata = '0;
    logic tx_bit_en = 1'b0;
    logic tx_bit, tx_empty_pulse;

    int errs = 0;
    int checks = 0;

    always #2 clk = ~clk;

    fdl_byte_buf #(.DW(DW), .ABORT_RUN(8)) dut (.*);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rx_send(input logic b, output logic f, output logic m, output logic a);
        @(negedge clk);
        rx_bit = b; rx_bit_en = 1'b1;
        @(negedge clk);
        rx_bit_en = 1'b0;
        f = rx_full_pulse; m = rx_match_pulse; a = rx_abort_pulse;
    endtask

    task automatic tx_group(output logic [DW-1:0] b, output int pulses);
        pulses = 0;
        for (int i = 0; i < DW; i++) begin
            @(negedge clk);
            b[i] = tx_bit; tx_bit_en = 1'b1;
            @(negedge clk);
            tx_bit_en = 1'b0;
            pulses += int'(tx_empty_pulse);
        end
    endtask

    task automatic tx_write(input logic [DW-1:0] v);
        @(negedge clk);
        tx_wr = 1'b1; tx_wdata = v;
        @(negedge clk);
        tx_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic f, m, a;
        logic [DW-1:0] tb;
        int p, fpos, fcnt, mcnt, acnt, apos;

        repeat (3) @(negedge clk);
        // R10: reset state
        check(rx_byte == 0 && !rx_full_pulse && !rx_match_pulse && !rx_abort_pulse,
              "R10 rx reset", int'(rx_byte), 0);
        check(tx_bit == 1'b1 && !tx_empty_pulse, "R10 tx reset", int'(tx_bit), 1);
        rst_n = 1'b1;

        // vector table: R1 R2 R3
        for (int v = 0; v < NV; v++) begin
            fcnt = 0; mcnt = 0; fpos = -1;
            for (int i = 0; i < DW; i++) begin
                rx_send(VEC[v][i], f, m, a);
                if (f) begin fcnt++; fpos = i; end
                if (m) mcnt++;
            end
            check(fcnt == 1 && fpos == DW-1, "R2 full on eighth bit", fpos, DW-1);
            check(rx_byte == VEC[v][DW-1:0], "R1 lsb-first byte", int'(rx_byte), int'(VEC[v][DW-1:0]));
            check(mcnt == int'(VEC[v][DW]), "R3 match", mcnt, int'(VEC[v][DW]));
        end

        // R5: unstrobed ones leave the run alone
        rx_send(1'b0, f, m, a);
        acnt = 0;
        for (int i = 0; i < 4; i++) begin rx_send(1'b1, f, m, a); acnt += int'(a); end
        @(negedge clk); rx_bit = 1'b1;
        for (int i = 0; i < 20; i++) begin @(negedge clk); acnt += int'(rx_abort_pulse); end
        check(acnt == 0, "R5 unstrobed ignored", acnt, 0);
        apos = -1;
        for (int i = 0; i < 4; i++) begin rx_send(1'b1, f, m, a); if (a) apos = i; end
        check(apos == 3, "R5 run kept across unstrobed gap", apos, 3);

        // R4 R5: long run fires once on eighth one
        rx_send(1'b0, f, m, a);
        acnt = 0; apos = -1;
        for (int i = 0; i < 12; i++) begin
            rx_send(1'b1, f, m, a);
            if (a) begin acnt++; apos = i; end
        end
        check(apos == 7, "R4 abort on eighth one", apos, 7);
        check(acnt == 1, "R5 abort once per run", acnt, 1);

        // R5: zero restarts the run
        rx_send(1'b0, f, m, a);
        acnt = 0;
        for (int i = 0; i < 7; i++) begin rx_send(1'b1, f, m, a); acnt += int'(a); end
        rx_send(1'b0, f, m, a); acnt += int'(a);
        for (int i = 0; i < 7; i++) begin rx_send(1'b1, f, m, a); acnt += int'(a); end
        check(acnt == 0, "R5 zero restarts run", acnt, 0);

        // transmit: R8 idle with nothing held, R7 no pulse
        tx_group(tb, p);
        check(tb == 8'hFF, "R8 idle ones", int'(tb), 8'hFF);
        check(p == 0, "R7 no pulse when empty", p, 0);

        // R9 R7 R6: single load
        tx_write(8'h96);
        tx_group(tb, p);
        check(tb == 8'hFF, "R8 idle before load", int'(tb), 8'hFF);
        check(p == 1, "R7 pulse on take", p, 1);
        tx_group(tb, p);
        check(tb == 8'h96, "R6 lsb-first byte out", int'(tb), 8'h96);
        check(p == 0, "R7 no second pulse", p, 0);
        tx_group(tb, p);
        check(tb == 8'hFF, "R8 idle after send", int'(tb), 8'hFF);

        // R9: overwrite while loaded
        tx_write(8'h11);
        tx_write(8'h5C);
        tx_group(tb, p);
        check(p == 1, "R7 one pulse after overwrite", p, 1);
        tx_group(tb, p);
        check(tb == 8'h5C, "R9 last write sent", int'(tb), 8'h5C);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule